// File: doc/BRIEF.md
# Eight-Line Serial Multiplexer Register Block

This block is the host-facing register file and line scanner for a group of eight asynchronous serial lines, reached over a 16-bit bus that supports both word and byte-lane writes. Four registers are selected by address bits 2:1. They are a control/status word, a shared receive queue that is popped by reads, a per-line enable and data-terminal-ready word, and a transmit port that hands one character at a time to the line the block currently offers. The parameter `NGROUPS` sets how many eight-line groups are built. Each group has its own state and takes the next eight bytes of the address window.

The receive queue is loaded through a simple push port. Per-line carrier, transmit-buffer-empty and ring inputs arrive as vectors. After every accepted register write, a round-robin scanner looks at the lines that follow the current transmit line. It offers the first line that is enabled, connected and idle by setting a ready flag and a three-bit line field in the control word. Accepted characters leave as a one-cycle strobe that carries a global line number and a byte.

Top module: `serial_mux`

## Requirements
- R1: A bus access is acknowledged only when its offset lies in 010..047 octal and `(offset>>3)-1` is below `NGROUPS`. Any other offset gets no acknowledge and reads as 0.
- R2: A control-word write with bit 4 (clear) set leaves the control word at 0, empties the receive queue and zeroes every line enable of the group. Data-terminal-ready bits are kept, and no scan takes place.
- R3: The control word resets to 0. A normal control-word write changes only bits 14, 12, 6, 5 and 3 (transmit-interrupt enable, alarm enable, receive-interrupt enable, scan enable, maintenance). Every other bit keeps its value until the scan step of R6.
- R4: A byte write to an odd address takes the high byte from the bus and keeps the current low byte. A byte write to an even address takes the low byte from the bus and keeps the current high byte.
- R5: A transmit write (offset 6) is dropped when ready (bit 15) is clear, and also when it writes the high byte only. An accepted write produces, one cycle later, a strobe carrying the line in bits 10:8 and the low data byte. The strobe fires only if that line is enabled and its carrier is present.
- R6: Every accepted write that is not a clear clears ready. If scan enable (bit 5) is set, lines current+1 to current+8 (modulo 8) are tested in that order. The first line that is enabled, has carrier and has an empty transmit buffer sets ready and is written into bits 10:8.
- R7: A receive read (offset 2) with scan enable clear returns 0 and changes nothing. Otherwise it returns `{1, 0000, line[2:0], char[7:0]}`, or 0 if the queue is empty. It also clears alarm (bit 13) and receive-done (bit 7), pops one entry, and sets receive-done again if entries remain.
- R8: A read of offset 6 returns the carrier bits in the high byte and the latched ring bits in the low byte. After the read, the ring latch holds only the ring pulses that arrive in that same cycle.
- R9: Offset 4 reads line enables in the low byte and data-terminal-ready bits in the high byte. It is written the same way. The `dtr` output mirrors the stored bits.
- R10: `irq` of a group is high exactly when (bit 7 and bit 6) or (bit 15 and bit 14) of its control word are set.
- R11: The receive queue holds 64 entries, and a push into a full queue is dropped. A push sets receive-done. If alarm enable is set and the push leaves at least 16 entries queued, it also sets alarm.
- R12: A write to offset 2 sets the receive-on flag of line `data[2:0]` to `data[12]`, and `rx_on` shows these flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | Byte access; bus_addr[0] picks the lane |
| bus_addr | input | ADDR_W | Byte offset in the block window |
| bus_wdata | input | 16 | Write data, lane aligned |
| bus_rdata | output | 16 | Read data, same cycle |
| bus_ack | output | 1 | Access decoded |
| carrier | input | 8*NGROUPS | Per-line connection status |
| tx_empty | input | 8*NGROUPS | Per-line transmit buffer empty |
| ring | input | 8*NGROUPS | Per-line ring pulses |
| rx_push | input | 1 | Receive queue write strobe |
| rx_line | input | LW | Line of the pushed character |
| rx_char | input | 8 | Pushed character |
| tx_strobe | output | 1 | Character leaves |
| tx_line | output | LW | Its global line number |
| tx_char | output | 8 | Its byte |
| dtr | output | 8*NGROUPS | Data-terminal-ready flags |
| rx_on | output | 8*NGROUPS | Receive-on flags |
| irq | output | NGROUPS | Interrupt request per group |

## Verification
The checker watches five properties on every cycle: no acknowledge outside the window, a zero control word after a clear, a transmit strobe only after a transmit write, ready rising only after a write and only with scan enable, and a zero receive read while scanning is off. The bench scenarios are needed for the rest. These are the order of the round-robin choice and its wrap past line 7, the byte-lane merges, the drop of a push into a full queue, the alarm threshold and the ring latch clearing on read. The bench checks each of these against values it works out from the register rules.

// File: rtl/smux_pkg.sv
package smux_pkg;
  localparam int GRP_LINES = 8;
  localparam int CSR_MAINT = 3;
  localparam int CSR_CLR   = 4;
  localparam int CSR_MSE   = 5;
  localparam int CSR_RIE   = 6;
  localparam int CSR_RDONE = 7;
  localparam int CSR_TL    = 8;
  localparam int CSR_SAE   = 12;
  localparam int CSR_SA    = 13;
  localparam int CSR_TIE   = 14;
  localparam int CSR_TRDY  = 15;
  localparam logic [15:0] CSR_WMASK = 16'h5068;

  typedef enum logic [1:0] {
    SEL_CSR  = 2'd0,
    SEL_RBUF = 2'd1,
    SEL_LINE = 2'd2,
    SEL_XMIT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] line;
    logic [7:0] ch;
  } rx_entry_t;

  // Combine a lane-aligned write with the current register contents.
  function automatic logic [15:0] merge_lanes(input logic [15:0] cur,
                                              input logic [15:0] wd,
                                              input logic byte_acc,
                                              input logic odd);
    if (!byte_acc) return wd;
    if (odd) return {wd[15:8], cur[7:0]};
    return {cur[15:8], wd[7:0]};
  endfunction

  // Round-robin choice: bit 3 = found, bits 2:0 = line.
  function automatic logic [3:0] scan_pick(input logic [2:0] cur,
                                           input logic [7:0] elig);
    logic [3:0] res;
    logic [2:0] idx;
    res = 4'd0;
    for (int i = 1; i <= GRP_LINES; i++) begin
      idx = cur + 3'(i);
      if (!res[3] && elig[idx]) res = {1'b1, idx};
    end
    return res;
  endfunction

  function automatic logic [15:0] rx_word(input rx_entry_t e);
    return {1'b1, 4'b0000, e.line, e.ch};
  endfunction
endpackage

// File: rtl/smux_fifo.sv
module smux_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/smux_group.sv
module smux_group
  import smux_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int ALARM_LEVEL = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        rd,
  input  logic [1:0]  sel,
  input  logic        odd,
  input  logic        byte_acc,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic [7:0]  conn,
  input  logic [7:0]  txe,
  input  logic [7:0]  ring_in,
  input  logic        push,
  input  rx_entry_t   push_entry,
  output logic [15:0] csr,
  output logic        irq,
  output logic        tx_fire,
  output logic [2:0]  tx_ln,
  output logic [7:0]  tx_ch,
  output logic [7:0]  dtr,
  output logic [7:0]  rx_on
);
  logic [15:0] csr_q, csr_d;
  logic [7:0]  en_q, en_d, dtr_q, dtr_d, rxon_q, rxon_d, ring_q, ring_d;
  logic [15:0] csr_m, line_m;
  logic        do_clear, xmit_ok, fire, pop, push_ok, pop_ok;
  logic [3:0]  pick;
  logic [2:0]  tl;
  logic [CW-1:0] cnt, cnt_after;
  logic        f_empty, f_full;
  rx_entry_t   head;
  logic [10:0] head_raw;
  reg_sel_e    rsel;

  assign rsel = reg_sel_e'(sel);
  assign tl   = csr_q[CSR_TL +: 3];
  assign head = rx_entry_t'(head_raw);

  smux_fifo #(.DEPTH(FIFO_DEPTH), .W($bits(rx_entry_t))) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(do_clear),
    .push(push), .din(push_entry), .pop(pop),
    .dout(head_raw), .count(cnt), .empty(f_empty), .full(f_full)
  );

  always_comb begin
    csr_m    = merge_lanes(csr_q, wdata, byte_acc, odd);
    line_m   = merge_lanes({dtr_q, en_q}, wdata, byte_acc, odd);
    do_clear = wr && rsel == SEL_CSR && csr_m[CSR_CLR];
    csr_d    = csr_q;
    en_d     = en_q;
    dtr_d    = dtr_q;
    rxon_d   = rxon_q;
    if (wr && rsel == SEL_CSR)
      csr_d = (csr_q & ~CSR_WMASK) | (csr_m & CSR_WMASK);
    if (wr && rsel == SEL_LINE) begin
      en_d  = line_m[7:0];
      dtr_d = line_m[15:8];
    end
    if (wr && rsel == SEL_RBUF) rxon_d[wdata[2:0]] = wdata[12];
    xmit_ok = wr && rsel == SEL_XMIT && !(byte_acc && odd) && csr_q[CSR_TRDY];
    fire    = xmit_ok && en_q[tl] && conn[tl];
    pick    = scan_pick(csr_d[CSR_TL +: 3], en_d & conn & txe);
    if (wr) begin
      csr_d[CSR_TRDY] = 1'b0;
      if (csr_d[CSR_MSE] && pick[3]) begin
        csr_d[CSR_TRDY]     = 1'b1;
        csr_d[CSR_TL +: 3]  = pick[2:0];
      end
    end
    pop    = rd && rsel == SEL_RBUF && csr_q[CSR_MSE];
    pop_ok = pop && !f_empty;
    if (pop) begin
      csr_d[CSR_SA]    = 1'b0;
      csr_d[CSR_RDONE] = pop_ok && (cnt > CW'(1));
    end
    push_ok   = push && !f_full && !do_clear;
    cnt_after = cnt - CW'(pop_ok) + CW'(push_ok);
    if (push_ok) begin
      csr_d[CSR_RDONE] = 1'b1;
      if (csr_d[CSR_SAE] && cnt_after >= CW'(ALARM_LEVEL)) csr_d[CSR_SA] = 1'b1;
    end
    if (do_clear) begin
      csr_d = '0;
      en_d  = '0;
    end
    ring_d = (rd && rsel == SEL_XMIT) ? ring_in : (ring_q | ring_in);
  end

  always_comb begin
    unique case (rsel)
      SEL_CSR:  rdata = csr_q;
      SEL_RBUF: rdata = (csr_q[CSR_MSE] && !f_empty) ? rx_word(head) : 16'h0000;
      SEL_LINE: rdata = {dtr_q, en_q};
      default:  rdata = {conn, ring_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q   <= '0;
      en_q    <= '0;
      dtr_q   <= '0;
      rxon_q  <= '0;
      ring_q  <= '0;
      tx_fire <= 1'b0;
      tx_ln   <= '0;
      tx_ch   <= '0;
    end else begin
      csr_q   <= csr_d;
      en_q    <= en_d;
      dtr_q   <= dtr_d;
      rxon_q  <= rxon_d;
      ring_q  <= ring_d;
      tx_fire <= fire;
      tx_ln   <= tl;
      tx_ch   <= wdata[7:0];
    end
  end

  assign csr   = csr_q;
  assign dtr   = dtr_q;
  assign rx_on = rxon_q;
  assign irq   = (csr_q[CSR_RDONE] && csr_q[CSR_RIE]) ||
                 (csr_q[CSR_TRDY] && csr_q[CSR_TIE]);
endmodule

// File: rtl/serial_mux.sv
module serial_mux
  import smux_pkg::*;
#(
  parameter int NGROUPS     = 1,
  parameter int ADDR_W      = 6,
  parameter int FIFO_DEPTH  = 64,
  parameter int ALARM_LEVEL = 16,
  localparam int NL = NGROUPS * GRP_LINES,
  localparam int LW = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_ack,
  input  logic [NL-1:0]     carrier,
  input  logic [NL-1:0]     tx_empty,
  input  logic [NL-1:0]     ring,
  input  logic              rx_push,
  input  logic [LW-1:0]     rx_line,
  input  logic [7:0]        rx_char,
  output logic              tx_strobe,
  output logic [LW-1:0]     tx_line,
  output logic [7:0]        tx_char,
  output logic [NL-1:0]     dtr,
  output logic [NL-1:0]     rx_on,
  output logic [NGROUPS-1:0] irq
);
  int          addr_i, grp_i;
  logic        in_window;
  logic        wr_ok, rd_ok;
  logic [15:0] g_rdata [NGROUPS];
  logic [15:0] g_csr   [NGROUPS];
  logic [2:0]  g_txl   [NGROUPS];
  logic [7:0]  g_txc   [NGROUPS];
  logic [NGROUPS-1:0] g_fire;
  rx_entry_t   entry;

  assign addr_i    = int'(bus_addr);
  assign grp_i     = (addr_i >> 3) - 1;
  assign in_window = (addr_i >= 8) && (addr_i <= 39);
  assign bus_ack   = bus_req && in_window && (grp_i < NGROUPS);
  assign wr_ok     = bus_ack && bus_wr;
  assign rd_ok     = bus_ack && !bus_wr;
  assign entry     = '{line: rx_line[2:0], ch: rx_char};

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    smux_group #(.FIFO_DEPTH(FIFO_DEPTH), .ALARM_LEVEL(ALARM_LEVEL)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_ok && grp_i == g), .rd(rd_ok && grp_i == g),
      .sel(bus_addr[2:1]), .odd(bus_addr[0]), .byte_acc(bus_byte),
      .wdata(bus_wdata), .rdata(g_rdata[g]),
      .conn(carrier[g*GRP_LINES +: GRP_LINES]),
      .txe(tx_empty[g*GRP_LINES +: GRP_LINES]),
      .ring_in(ring[g*GRP_LINES +: GRP_LINES]),
      .push(rx_push && ((int'(rx_line) >> 3) == g)), .push_entry(entry),
      .csr(g_csr[g]), .irq(irq[g]),
      .tx_fire(g_fire[g]), .tx_ln(g_txl[g]), .tx_ch(g_txc[g]),
      .dtr(dtr[g*GRP_LINES +: GRP_LINES]),
      .rx_on(rx_on[g*GRP_LINES +: GRP_LINES])
    );
  end

  always_comb begin
    bus_rdata = 16'h0000;
    tx_strobe = 1'b0;
    tx_line   = '0;
    tx_char   = '0;
    for (int g = 0; g < NGROUPS; g++) begin
      if (rd_ok && grp_i == g) bus_rdata = g_rdata[g];
      if (g_fire[g]) begin
        tx_strobe = 1'b1;
        tx_line   = LW'(g * GRP_LINES + int'(g_txl[g]));
        tx_char   = g_txc[g];
      end
    end
  end
endmodule

// File: rtl/serial_mux_chk.sv
module serial_mux_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic              bus_byte,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              bus_ack,
  input logic              wr_ok,
  input logic              tx_strobe,
  input logic [15:0]       csr0
);
  // R1: offsets outside the window are never acknowledged
  p_ack_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && (int'(bus_addr) < 8 || int'(bus_addr) > 39) |-> !bus_ack);

  // R2: a clearing word write leaves the first group's control word at zero
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && int'(bus_addr) == 8 && !bus_byte && bus_wdata[4] |=> csr0 == 16'h0000);

  // R5: a character leaves only after an accepted transmit-register write
  p_tx_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> $past(wr_ok && bus_addr[2:1] == 2'd3));

  // R6: ready rises only as the result of a write
  p_trdy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr0[15]) |-> $past(wr_ok));

  // R6: ready never stands while scanning is disabled
  p_trdy_mse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    csr0[15] |-> csr0[5]);

  // R7: receive read with scanning off returns zero
  p_rbuf_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_wr && bus_ack && int'(bus_addr[ADDR_W-1:1]) == 5 && !csr0[5]
      |-> bus_rdata == 16'h0000);
endmodule

bind serial_mux serial_mux_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_ack(bus_ack), .wr_ok(wr_ok),
  .tx_strobe(tx_strobe), .csr0(g_csr[0])
);

// File: tb/tb_serial_mux.sv
module tb_serial_mux;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_req = 0, bus_wr = 0, bus_byte = 0;
  logic [5:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic [7:0]  carrier = 8'h26, tx_empty = 8'hFF, ring = 8'h00;
  logic        rx_push = 0;
  logic [2:0]  rx_line = 0;
  logic [7:0]  rx_char = 0;
  logic        tx_strobe;
  logic [2:0]  tx_line;
  logic [7:0]  tx_char;
  logic [7:0]  dtr, rx_on;
  logic [0:0]  irq;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_mux dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .carrier(carrier),
    .tx_empty(tx_empty), .ring(ring), .rx_push(rx_push), .rx_line(rx_line),
    .rx_char(rx_char), .tx_strobe(tx_strobe), .tx_line(tx_line),
    .tx_char(tx_char), .dtr(dtr), .rx_on(rx_on), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic        byt;
    logic [5:0]  addr;
    logic [15:0] data;
    logic        chk;
    logic        ack;
    logic [15:0] exp;
    logic        txchk;
    logic        txv;
    logic [2:0]  txl;
    logic [7:0]  txc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{0,0,6'o10,16'h0000,1,1,16'h0000,0,0,0,8'h00,4'd3},  // R3 reset value
    '{0,0,6'o07,16'h0000,1,0,16'h0000,0,0,0,8'h00,4'd1},  // R1 below window
    '{0,0,6'o50,16'h0000,1,0,16'h0000,0,0,0,8'h00,4'd1},  // R1 above window
    '{0,0,6'o20,16'h0000,1,0,16'h0000,0,0,0,8'h00,4'd1},  // R1 group beyond count
    '{1,0,6'o14,16'h0306,0,1,16'h0000,1,0,0,8'h00,4'd9},  // R9 enables 1,2 dtr 0,1
    '{0,0,6'o14,16'h0000,1,1,16'h0306,0,0,0,8'h00,4'd9},  // R9 readback
    '{1,0,6'o10,16'h4020,0,1,16'h0000,0,0,0,8'h00,4'd6},  // R6 scan on
    '{0,0,6'o10,16'h0000,1,1,16'hC120,0,0,0,8'h00,4'd6},  // R6 line 1 offered
    '{1,0,6'o16,16'h0041,0,1,16'h0000,1,1,3'd1,8'h41,4'd5}, // R5 send on 1
    '{1,0,6'o16,16'h0042,0,1,16'h0000,1,1,3'd2,8'h42,4'd5}, // R5 send on 2
    '{0,0,6'o10,16'h0000,1,1,16'hC120,0,0,0,8'h00,4'd6},  // R6 wrap to 1
    '{1,1,6'o17,16'h4300,0,1,16'h0000,1,0,0,8'h00,4'd5},  // R5 high byte dropped
    '{0,0,6'o10,16'h0000,1,1,16'hC220,0,0,0,8'h00,4'd6},  // R6 rescan to 2
    '{1,1,6'o11,16'h0000,0,1,16'h0000,0,0,0,8'h00,4'd4},  // R4 odd lane
    '{0,0,6'o10,16'h0000,1,1,16'h8120,0,0,0,8'h00,4'd4},  // R4 low kept
    '{1,1,6'o10,16'h0060,0,1,16'h0000,0,0,0,8'h00,4'd4},  // R4 even lane
    '{0,0,6'o10,16'h0000,1,1,16'h8260,0,0,0,8'h00,4'd4},  // R4 high kept
    '{1,0,6'o14,16'h0000,0,1,16'h0000,0,0,0,8'h00,4'd6},  // R6 nothing eligible
    '{1,0,6'o16,16'h0055,0,1,16'h0000,1,0,0,8'h00,4'd5},  // R5 not ready
    '{0,0,6'o10,16'h0000,1,1,16'h0260,0,0,0,8'h00,4'd3}   // R3 preserved bits
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic byt, input logic [5:0] addr,
                     input logic [15:0] data, output logic [15:0] rd, output logic ack);
    @(negedge clk);
    bus_req = 1; bus_wr = wr; bus_byte = byt; bus_addr = addr; bus_wdata = data;
    #1;
    rd = bus_rdata; ack = bus_ack;
    @(negedge clk);
    bus_req = 0; bus_wr = 0; bus_byte = 0;
  endtask

  task automatic push(input logic [2:0] ln, input logic [7:0] ch);
    @(negedge clk);
    rx_push = 1; rx_line = ln; rx_char = ch;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic ack;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset irq", irq, 0);
    chk("R3 reset dtr", dtr, 0);
    chk("R12 reset rx_on", rx_on, 0);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].wr, VECS[i].byt, VECS[i].addr, VECS[i].data, rd, ack);
      chk($sformatf("R%0d ack row %0d", VECS[i].req, i), ack, VECS[i].ack);
      if (VECS[i].chk)
        chk($sformatf("R%0d data row %0d", VECS[i].req, i), rd, VECS[i].exp);
      if (VECS[i].txchk) begin
        chk($sformatf("R%0d strobe row %0d", VECS[i].req, i), tx_strobe, VECS[i].txv);
        if (VECS[i].txv)
          chk($sformatf("R%0d tx row %0d", VECS[i].req, i), {tx_line, tx_char},
              {VECS[i].txl, VECS[i].txc});
      end
    end

    // R7 empty queue, then three entries
    bus(0, 0, 6'o12, 0, rd, ack); chk("R7 empty read", rd, 16'h0000);
    push(3'd5, 8'h61); push(3'd5, 8'h62); push(3'd5, 8'h63);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R11 rdone on push", rd, 16'h02E0);
    chk("R10 irq rx", irq, 1);
    bus(0, 0, 6'o12, 0, rd, ack); chk("R7 pop 1", rd, 16'h8561);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R7 rdone kept", rd, 16'h02E0);
    bus(0, 0, 6'o12, 0, rd, ack); chk("R7 pop 2", rd, 16'h8562);
    bus(0, 0, 6'o12, 0, rd, ack); chk("R7 pop 3", rd, 16'h8563);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R7 rdone cleared", rd, 16'h0260);
    chk("R10 irq idle", irq, 0);

    // R10 / R5 transmit interrupt, carrier lost
    bus(1, 0, 6'o14, 16'h0002, rd, ack);
    bus(1, 0, 6'o10, 16'h4020, rd, ack);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R6 offered 1", rd, 16'hC120);
    chk("R10 irq tx", irq, 1);
    carrier = 8'h00;
    bus(1, 0, 6'o16, 16'h0077, rd, ack);
    chk("R5 no carrier no strobe", tx_strobe, 0);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R6 no line", rd, 16'h4120);
    chk("R10 irq drop", irq, 0);
    carrier = 8'h26;

    // R7 scan disabled read
    bus(1, 0, 6'o10, 16'h0000, rd, ack);
    push(3'd0, 8'h5A);
    bus(0, 0, 6'o12, 0, rd, ack); chk("R7 mse off read", rd, 16'h0000);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R7 no pop", rd, 16'h0180);
    bus(1, 0, 6'o10, 16'h0020, rd, ack);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R3 rdone preserved", rd, 16'h81A0);
    bus(0, 0, 6'o12, 0, rd, ack); chk("R7 entry", rd, 16'h805A);

    // R11 alarm threshold and depth
    bus(1, 0, 6'o10, 16'h1020, rd, ack);
    for (int k = 0; k < 15; k++) push(3'd0, 8'(k));
    bus(0, 0, 6'o10, 0, rd, ack); chk("R11 below alarm", rd, 16'h91A0);
    push(3'd0, 8'd15);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R11 alarm at 16", rd, 16'hB1A0);
    bus(0, 0, 6'o12, 0, rd, ack); chk("R7 pop first", rd, 16'h8000);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R7 alarm cleared", rd, 16'h91A0);
    for (int k = 16; k <= 64; k++) push(3'd0, 8'(k));
    push(3'd0, 8'hEE);
    bad = 0;
    for (int k = 1; k <= 64; k++) begin
      bus(0, 0, 6'o12, 0, rd, ack);
      if (rd !== (16'h8000 | 16'(k))) bad++;
    end
    chk("R11 64 entries in order", bad, 0);
    bus(0, 0, 6'o12, 0, rd, ack); chk("R11 full push dropped", rd, 16'h0000);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R7 drained", rd, 16'h9120);

    // R2 clear
    bus(1, 0, 6'o14, 16'h0306, rd, ack);
    push(3'd1, 8'h11); push(3'd2, 8'h22);
    chk("R9 dtr out", dtr, 8'h03);
    bus(1, 0, 6'o10, 16'h0010, rd, ack);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R2 csr zero", rd, 16'h0000);
    bus(0, 0, 6'o14, 0, rd, ack); chk("R2 enables dropped", rd, 16'h0300);
    bus(1, 0, 6'o10, 16'h0020, rd, ack);
    bus(0, 0, 6'o10, 0, rd, ack); chk("R2 queue empty", rd, 16'h0020);
    bus(0, 0, 6'o12, 0, rd, ack); chk("R2 nothing queued", rd, 16'h0000);

    // R8 ring latch
    @(negedge clk); ring = 8'h08;
    @(negedge clk); ring = 8'h00;
    bus(0, 0, 6'o16, 0, rd, ack); chk("R8 ring and carrier", rd, 16'h2608);
    bus(0, 0, 6'o16, 0, rd, ack); chk("R8 ring cleared", rd, 16'h2600);

    // R12 line parameters
    bus(1, 0, 6'o12, 16'h1005, rd, ack); chk("R12 rx on", rx_on, 8'h20);
    bus(1, 0, 6'o12, 16'h0005, rd, ack); chk("R12 rx off", rx_on, 8'h00);

    done = 1;
    summary();
    $finish;
  end
endmodule